// File: doc/BRIEF.md
# Table-Indirect Descriptor Fetch Unit

This block turns a table-indirect block-move instruction into the two operands the data mover needs: a 24-bit byte count and a 32-bit physical data address. The host loads a base-address register before an I/O starts. When an instruction is handed over, the block adds the sign-extended 24-bit offset carried by the instruction to that base. It then reads two consecutive 32-bit words from memory at the resulting descriptor address. The word at the descriptor address holds the byte count, and the word four bytes above it holds the data address.

Memory is reached through a simple request/acknowledge read port. Exactly one read is in flight at a time, and the count is always read before the address. When both words have arrived, the block raises a one-cycle done pulse and holds the resolved operands on its outputs. A request is refused with a one-cycle error pulse, and no read is issued, in three cases: the base is not word aligned, the instruction's opcode bit names the reserved operation, or a memory-to-memory DMA is in progress.

Top module: `desc_fetch_unit`

## Requirements
- R1: After reset the unit is idle: `busy`, `mem_req`, `done_o` and `error_o` are 0, and `byte_count_o` and `data_addr_o` are 0.
- R2: `base_we` loads `base_wdata` into the base register only while the unit is idle. A start request while base bits [1:0] are not both 0 raises `error_o` and issues no read.
- R3: The descriptor address equals the base plus `instr_ofs` read as a 24-bit two's-complement value (bit 23 is the sign), modulo 2^32. Both positive and negative offsets work, and sums that pass 2^32 wrap.
- R4: The first read is issued at the descriptor address. Only bits [23:0] of the returned word appear on `byte_count_o`.
- R5: The second read is issued at the descriptor address plus 4, modulo 2^32, and only after the first read has been acknowledged. At most one read is outstanding at any time. `mem_addr` stays stable while `mem_req` waits for `mem_ack`.
- R6: `done_o` is high for exactly one cycle, in the cycle after the second acknowledge has been sampled. `data_addr_o` then holds the second word and `byte_count_o` holds the first, and both keep those values until the next successful fetch.
- R7: A start request made while `m2m_active` is 1 raises `error_o` and issues no read.
- R8: `instr_opc` is bit 27 of the instruction; 0 means block move and 1 is reserved. A start request with `instr_opc` = 1 raises `error_o` and issues no read.
- R9: While the unit is busy, `start` and `base_we` have no effect. The fetch in progress completes with its original operands, and the base keeps its previous value.
- R10: `error_o` is high for exactly one cycle, in the cycle after the refused start was sampled. The unit stays idle, and `byte_count_o` and `data_addr_o` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_we | input | 1 | Base-register write strobe |
| base_wdata | input | 32 | Base-register write value |
| start | input | 1 | Begin resolving the presented instruction |
| instr_opc | input | 1 | Opcode bit 27 of the instruction (0 = block move) |
| instr_ofs | input | 24 | Signed offset field of the instruction |
| m2m_active | input | 1 | A memory-to-memory DMA is executing |
| mem_req | output | 1 | Read request |
| mem_addr | output | 32 | Read address |
| mem_ack | input | 1 | Read acknowledge, with data valid |
| mem_rdata | input | 32 | Read data |
| busy | output | 1 | Fetch in progress |
| done_o | output | 1 | One-cycle pulse when the operands are resolved |
| error_o | output | 1 | One-cycle pulse when a request is refused |
| byte_count_o | output | 24 | Resolved byte count |
| data_addr_o | output | 32 | Resolved physical data address |

## Verification
The in-RTL assertions check on every cycle that:
- a pending read holds its address;
- done and error are single-cycle pulses;
- a refusal never coincides with a memory request;
- done always follows an acknowledge;
- a fetch only runs from an aligned base.

Other behaviours depend on data values and on the order of events, so only the directed scenarios can show them:
- the arithmetic value of the descriptor address for positive, negative and wrapping offsets;
- truncation of the count word;
- the plus-four spacing of the two reads;
- the refusal causes, and that the busy-time writes and starts are ignored.

// File: rtl/desc_fetch_pkg.sv
package desc_fetch_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_CALC   = 3'd1,
    ST_RD_CNT = 3'd2,
    ST_RD_ADR = 3'd3,
    ST_DONE   = 3'd4
  } fetch_state_t;
endpackage

// File: rtl/desc_fetch_addr.sv
// Base register, offset latch and descriptor address generation.
module desc_fetch_addr #(
  parameter int ADDR_W     = 32,
  parameter int OFS_W      = 24,
  parameter int ALIGN_BITS = 2,
  parameter int WORD_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              base_ld,
  input  logic [ADDR_W-1:0] base_wdata,
  input  logic              ofs_ld,
  input  logic [OFS_W-1:0]  ofs_in,
  input  logic              calc_en,
  input  logic              sel_second,
  output logic              base_misaligned,
  output logic [ADDR_W-1:0] rd_addr
);
  localparam int EXT_W = ADDR_W - OFS_W;

  logic [ADDR_W-1:0] base_q, desc_q, desc_d;
  logic [OFS_W-1:0]  ofs_q;
  logic [ADDR_W-1:0] ofs_sext;

  assign ofs_sext        = {{EXT_W{ofs_q[OFS_W-1]}}, ofs_q};
  assign desc_d          = base_q + ofs_sext;
  assign base_misaligned = |base_q[ALIGN_BITS-1:0];
  assign rd_addr         = sel_second ? desc_q + ADDR_W'(WORD_BYTES) : desc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      ofs_q  <= '0;
      desc_q <= '0;
    end else begin
      if (base_ld) base_q <= base_wdata;
      if (ofs_ld)  ofs_q  <= ofs_in;
      if (calc_en) desc_q <= desc_d;
    end
  end

  // A fetch only runs from an aligned base
  assert_calc_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
    calc_en |-> (base_q[ALIGN_BITS-1:0] == '0));
endmodule

// File: rtl/desc_fetch_ctrl.sv
// Sequencer: IDLE -> CALC -> READ_COUNT -> READ_ADDR -> DONE.
module desc_fetch_ctrl
  import desc_fetch_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic instr_opc,
  input  logic m2m_active,
  input  logic base_misaligned,
  input  logic mem_ack,
  output logic idle,
  output logic ofs_ld,
  output logic calc_en,
  output logic sel_second,
  output logic mem_req,
  output logic cnt_cap,
  output logic adr_cap,
  output logic done,
  output logic error
);
  fetch_state_t state_q, state_d;
  logic err_q, err_d, refuse, accept;

  assign idle   = (state_q == ST_IDLE);
  assign refuse = instr_opc | m2m_active | base_misaligned;
  assign accept = idle & start & ~refuse;
  assign err_d  = idle & start & refuse;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (accept) state_d = ST_CALC;
      ST_CALC:   state_d = ST_RD_CNT;
      ST_RD_CNT: if (mem_ack) state_d = ST_RD_ADR;
      ST_RD_ADR: if (mem_ack) state_d = ST_DONE;
      ST_DONE:   state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      err_q   <= err_d;
    end
  end

  assign ofs_ld     = accept;
  assign calc_en    = (state_q == ST_CALC);
  assign sel_second = (state_q == ST_RD_ADR);
  assign mem_req    = (state_q == ST_RD_CNT) | (state_q == ST_RD_ADR);
  assign cnt_cap    = (state_q == ST_RD_CNT) & mem_ack;
  assign adr_cap    = (state_q == ST_RD_ADR) & mem_ack;
  assign done       = (state_q == ST_DONE);
  assign error      = err_q;

  // The count read is always followed by the address read
  assert_count_then_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_cap |=> (sel_second && mem_req));
  // A refusal starts no sequence
  assert_refuse_stays_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> (idle && !mem_req));
endmodule

// File: rtl/desc_fetch_result.sv
// Holds the resolved operands for the data mover.
module desc_fetch_result #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cnt_cap,
  input  logic              adr_cap,
  input  logic [ADDR_W-1:0] rdata,
  output logic [CNT_W-1:0]  byte_count,
  output logic [ADDR_W-1:0] data_addr
);
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] adr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      adr_q <= '0;
    end else begin
      if (cnt_cap) cnt_q <= rdata[CNT_W-1:0];
      if (adr_cap) adr_q <= rdata;
    end
  end

  assign byte_count = cnt_q;
  assign data_addr  = adr_q;
endmodule

// File: rtl/desc_fetch_unit.sv
module desc_fetch_unit #(
  parameter int ADDR_W = 32,
  parameter int OFS_W  = 24,
  parameter int CNT_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              base_we,
  input  logic [ADDR_W-1:0] base_wdata,
  input  logic              start,
  input  logic              instr_opc,
  input  logic [OFS_W-1:0]  instr_ofs,
  input  logic              m2m_active,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic [ADDR_W-1:0] mem_rdata,
  output logic              busy,
  output logic              done_o,
  output logic              error_o,
  output logic [CNT_W-1:0]  byte_count_o,
  output logic [ADDR_W-1:0] data_addr_o
);
  logic idle, ofs_ld, calc_en, sel_second, cnt_cap, adr_cap, misaligned;

  desc_fetch_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .instr_opc(instr_opc),
    .m2m_active(m2m_active), .base_misaligned(misaligned), .mem_ack(mem_ack),
    .idle(idle), .ofs_ld(ofs_ld), .calc_en(calc_en), .sel_second(sel_second),
    .mem_req(mem_req), .cnt_cap(cnt_cap), .adr_cap(adr_cap),
    .done(done_o), .error(error_o)
  );

  desc_fetch_addr #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .base_ld(base_we & idle), .base_wdata(base_wdata),
    .ofs_ld(ofs_ld), .ofs_in(instr_ofs), .calc_en(calc_en),
    .sel_second(sel_second), .base_misaligned(misaligned), .rd_addr(mem_addr)
  );

  desc_fetch_result #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_res (
    .clk(clk), .rst_n(rst_n), .cnt_cap(cnt_cap), .adr_cap(adr_cap),
    .rdata(mem_rdata), .byte_count(byte_count_o), .data_addr(data_addr_o)
  );

  assign busy = ~idle;

  assert_addr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  assert_done_after_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(mem_ack));
  assert_error_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    error_o |=> !error_o);
  assert_error_no_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
    error_o |-> (!mem_req && !done_o));
endmodule

// File: tb/test_desc_fetch_unit.sv
module test_desc_fetch_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        base_we, start, instr_opc, m2m_active, mem_ack;
  logic [31:0] base_wdata, mem_rdata, mem_addr, data_addr_o;
  logic [23:0] instr_ofs, byte_count_o;
  logic        mem_req, busy, done_o, error_o;

  int n_chk = 0, n_bad = 0, n_reads = 0, cyc = 0, wait_cnt = 0, lat = 0;
  logic [31:0] rd_log [4];

  always #5 clk = ~clk;

  desc_fetch_unit i_desc_fetch_unit (
    .clk(clk), .rst_n(rst_n), .base_we(base_we), .base_wdata(base_wdata),
    .start(start), .instr_opc(instr_opc), .instr_ofs(instr_ofs),
    .m2m_active(m2m_active), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .busy(busy), .done_o(done_o),
    .error_o(error_o), .byte_count_o(byte_count_o), .data_addr_o(data_addr_o)
  );

  function automatic logic [31:0] mem_f(input logic [31:0] a);
    return a * 32'h9E37_79B1 + 32'h1234_5678;
  endfunction

  // Memory model: acknowledges after lat waiting negedges
  always @(negedge clk) begin
    cyc++;
    if (mem_ack) mem_ack = 1'b0;
    else if (mem_req) begin
      if (wait_cnt >= lat) begin
        mem_ack   = 1'b1;
        mem_rdata = mem_f(mem_addr);
        if (n_reads < 4) rd_log[n_reads] = mem_addr;
        n_reads++;
        wait_cnt = 0;
      end else wait_cnt++;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic write_base(input logic [31:0] b);
    @(negedge clk);
    base_we = 1'b1; base_wdata = b;
    @(negedge clk);
    base_we = 1'b0;
  endtask

  task automatic pulse_start(input logic opc, input logic [23:0] ofs);
    @(negedge clk);
    start = 1'b1; instr_opc = opc; instr_ofs = ofs;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output bit ok);
    ok = 0;
    for (int i = 0; i < 200; i++) begin
      if (done_o) begin ok = 1; break; end
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    chk("R1 busy", {31'b0, busy}, 32'd0);
    chk("R1 mem_req", {31'b0, mem_req}, 32'd0);
    chk("R1 done/error", {30'b0, done_o, error_o}, 32'd0);
    chk("R1 count", {8'b0, byte_count_o}, 32'd0);
    chk("R1 addr", data_addr_o, 32'd0);
  endtask

  // Full fetch; checks R3..R6
  task automatic t_fetch(input bit do_base, input logic [31:0] b, input logic [31:0] exp_base,
                         input logic [23:0] ofs, input int latency, input string tag);
    bit ok;
    logic [31:0] da;
    lat = latency;
    if (do_base) write_base(b);
    n_reads = 0;
    da = exp_base + {{8{ofs[23]}}, ofs};
    pulse_start(1'b0, ofs);
    wait_done(ok);
    chk({tag, " R6 done seen"}, {31'b0, ok}, 32'd1);
    chk({tag, " R5 read count"}, n_reads, 32'd2);
    chk({tag, " R3 R4 first addr"}, rd_log[0], da);
    chk({tag, " R5 second addr"}, rd_log[1], da + 32'd4);
    chk({tag, " R4 byte count"}, {8'b0, byte_count_o}, {8'b0, mem_f(da)[23:0]});
    chk({tag, " R6 data addr"}, data_addr_o, mem_f(da + 32'd4));
    @(negedge clk);
    chk({tag, " R6 done one cycle"}, {31'b0, done_o}, 32'd0);
    chk({tag, " R6 idle after"}, {31'b0, busy}, 32'd0);
    repeat (3) @(negedge clk);
    chk({tag, " R6 outputs held"}, data_addr_o, mem_f(da + 32'd4));
  endtask

  // Refused start; checks R2/R7/R8/R10
  task automatic t_refuse(input logic opc, input logic m2m, input string tag);
    logic [23:0] c0;
    logic [31:0] a0;
    c0 = byte_count_o; a0 = data_addr_o;
    n_reads = 0;
    m2m_active = m2m;
    @(negedge clk);
    start = 1'b1; instr_opc = opc; instr_ofs = 24'h000010;
    @(negedge clk);
    start = 1'b0;
    chk({tag, " R10 error pulse"}, {31'b0, error_o}, 32'd1);
    chk({tag, " R10 stays idle"}, {31'b0, busy}, 32'd0);
    @(negedge clk);
    chk({tag, " R10 error one cycle"}, {31'b0, error_o}, 32'd0);
    m2m_active = 1'b0;
    repeat (5) @(negedge clk);
    chk({tag, " no reads issued"}, n_reads, 32'd0);
    chk({tag, " R10 outputs kept"}, {8'b0, byte_count_o} ^ data_addr_o, {8'b0, c0} ^ a0);
  endtask

  // Start and base write while busy have no effect (R9)
  task automatic t_busy_ignore;
    bit ok;
    logic [31:0] da;
    write_base(32'h0000_4000);
    lat = 3; n_reads = 0;
    da = 32'h0000_4000 + 32'h20;
    pulse_start(1'b0, 24'h000020);
    @(negedge clk);
    start = 1'b1; instr_ofs = 24'h000100; base_we = 1'b1; base_wdata = 32'h0000_8000;
    @(negedge clk);
    start = 1'b0; base_we = 1'b0;
    wait_done(ok);
    chk("R9 done seen", {31'b0, ok}, 32'd1);
    chk("R9 reads", n_reads, 32'd2);
    chk("R9 first addr unchanged", rd_log[0], da);
    chk("R9 data addr", data_addr_o, mem_f(da + 32'd4));
    @(negedge clk);
    // Base must still be the old one
    t_fetch(1'b0, 32'h0, 32'h0000_4000, 24'h000000, 0, "R9 base kept");
  endtask

  initial begin
    rst_n = 1'b0; base_we = 0; base_wdata = 0; start = 0; instr_opc = 0;
    instr_ofs = 0; m2m_active = 0; mem_ack = 0; mem_rdata = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fetch(1'b1, 32'h0000_1000, 32'h0000_1000, 24'h000040, 0, "R3 positive");
    t_fetch(1'b1, 32'h0000_1000, 32'h0000_1000, 24'hFFFFF0, 2, "R3 negative");
    t_fetch(1'b1, 32'hFFFF_FFF8, 32'hFFFF_FFF8, 24'h000004, 1, "R3 wrap");
    t_fetch(1'b1, 32'h8000_0000, 32'h8000_0000, 24'h800000, 0, "R3 min offset");
    t_refuse(1'b1, 1'b0, "R8 reserved opcode");
    t_refuse(1'b0, 1'b1, "R7 m2m active");
    write_base(32'h0000_2002);
    t_refuse(1'b0, 1'b0, "R2 misaligned base");
    t_busy_ignore();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    wait (cyc > 20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d expected < 20000 cycles", cyc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule